// File: doc/BRIEF.md
# Receive Buffer Ring DMA Manager

This block computes the local memory write addresses used to store received packets in a circular set of fixed 256-byte pages. The pages sit inside a 16-bit byte address space. The upper address byte is the page number and the lower byte is the offset inside that page. Two configuration inputs bound the ring: a first page and an end page, where the end page is exclusive. A third input, written by the host, names the oldest page that software has not yet read.

A packet is framed by a start strobe and byte-valid pulses, and it ends with either an accept strobe or a reject strobe. Every byte is written to memory one cycle after it arrives. A packet that fills a page carries on at offset 0 of the next page, and the page after the last one in the ring is the first page. On accept, the current-page output moves past the pages the packet used. On reject, or when the packet runs into the host's unread page, the current page stays where it was, so the next packet reuses those pages. Moving the boundary forward gives pages back to the writer.

Top module: `rx_ring_dma`

## Requirements
- R1: One cycle after reset is released, `curr_page_o` equals `page_start_i`, `overflow_o` is 0 and `mem_we_o` is 0. The first byte of the first packet is written to address {page_start_i, 8'h00}.
- R2: In a receiving packet, each byte presented with `rx_valid_i` appears on `mem_data_o` with `mem_we_o`=1 one cycle later. Successive bytes of one packet go to successive byte addresses.
- R3: After a byte written at offset 8'hFF of page P, the next byte of the same packet is written at offset 8'h00 of page P+1.
- R4: When P+1 equals `page_stop_i`, the next page is `page_start_i` instead, so no write lands on a page at or above `page_stop_i`.
- R5: On `rx_accept_i`, `curr_page_o` becomes the page after the last page that holds a byte of the packet, with the wrap of R4 applied. A packet that ends exactly at offset 8'hFF moves `curr_page_o` to the following page and does not set `overflow_o`.
- R6: On `rx_reject_i`, `curr_page_o` is unchanged, and the next packet is written again from offset 0 of that same page.
- R7: A byte that would be written at offset 0 of the page equal to `boundary_i` is not written, and `overflow_o` goes to 1. No later byte of that packet is written. An accept for that packet leaves `curr_page_o` unchanged. The next start strobe clears `overflow_o`.
- R8: Once the host changes `boundary_i` to another page, a page that was blocked before can be written again.
- R9: While `page_stop_i` <= `page_start_i`, start strobes are ignored and no write takes place. After the values become valid again, packets are written from `curr_page_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| page_start_i | input | 8 | First page of the ring |
| page_stop_i | input | 8 | Page one past the last page of the ring |
| boundary_i | input | 8 | Oldest page not yet read by the host |
| rx_start_i | input | 1 | Start of a received packet |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| rx_accept_i | input | 1 | End of packet, keep it |
| rx_reject_i | input | 1 | End of packet, discard it |
| mem_addr_o | output | 16 | Memory write byte address |
| mem_data_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| curr_page_o | output | 8 | First page of the next packet to be stored |
| overflow_o | output | 1 | Last packet hit the unread boundary |

## Verification
The hardest situations to reach are the ones where a page crossing and the ring wrap happen inside one packet: a packet that runs from the last ring page back into the first page, and a packet that meets the boundary page partway through. Reaching them takes several hundred bytes, with the boundary placed so the earlier packets pass it and later ones are stopped. The bench therefore drives a sequence of packets with chosen lengths over a four-page ring and moves the host boundary between packets. This walks the current page all the way round the ring. The same sequence also covers a packet that ends exactly at a page end while the boundary sits on the following page, so an off-by-one in the boundary check would show up as a false overflow.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_DROP = 2'd2
  } rx_state_e;
endpackage

// File: rtl/rx_ring_wptr.sv
module rx_ring_wptr #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PAGE_W-1:0] load_page_i,
  input  logic              recv_i,
  input  logic              cfg_ok_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic [PAGE_W-1:0] boundary_i,
  input  logic [PAGE_W-1:0] page_start_i,
  input  logic [PAGE_W-1:0] page_stop_i,
  output logic              hit_bnd_o,
  output logic [PAGE_W-1:0] end_page_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              mem_we_o
);
  localparam int OFF_W = ADDR_W - PAGE_W;

  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q;
  logic [PAGE_W-1:0] page_inc;
  logic [PAGE_W-1:0] page_step;
  logic              at_entry;
  logic              byte_in;
  logic              do_wr;

  assign page_inc  = page_q + 1'b1;
  assign page_step = (page_inc == page_stop_i) ? page_start_i : page_inc;
  assign at_entry  = (off_q == '0);
  assign byte_in   = recv_i && cfg_ok_i && rx_valid_i;
  // entering a page is checked lazily, only when a byte actually needs it
  assign hit_bnd_o  = byte_in && at_entry && (page_q == boundary_i);
  assign do_wr      = byte_in && !hit_bnd_o;
  assign end_page_o = at_entry ? page_q : page_step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      off_q  <= '0;
    end else if (load_i) begin
      page_q <= load_page_i;
      off_q  <= '0;
    end else if (do_wr) begin
      if (&off_q) begin
        page_q <= page_step;
        off_q  <= '0;
      end else begin
        off_q <= off_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o   <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
    end else begin
      mem_we_o <= do_wr;
      if (do_wr) begin
        mem_addr_o <= {page_q, off_q};
        mem_data_o <= rx_data_i;
      end
    end
  end

  AST_NO_BND_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !((mem_addr_o[OFF_W-1:0] == '0) &&
                   (mem_addr_o[ADDR_W-1:OFF_W] == $past(boundary_i)))); // R7

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o) && (mem_addr_o[OFF_W-1:0] != '0))
      |-> (mem_addr_o == $past(mem_addr_o) + 1'b1)); // R2

  AST_PAGE_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o) && (mem_addr_o[OFF_W-1:0] == '0))
      |-> (mem_addr_o[ADDR_W-1:OFF_W] ==
           ((($past(mem_addr_o[ADDR_W-1:OFF_W]) + 1'b1) == $past(page_stop_i)) ?
             $past(page_start_i) : $past(mem_addr_o[ADDR_W-1:OFF_W]) + 1'b1))); // R3

  AST_WR_IN_RING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ((mem_addr_o[ADDR_W-1:OFF_W] >= $past(page_start_i)) &&
                  (mem_addr_o[ADDR_W-1:OFF_W] <  $past(page_stop_i)))); // R4
endmodule

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PAGE_W-1:0] page_start_i,
  input  logic [PAGE_W-1:0] page_stop_i,
  input  logic              rx_start_i,
  input  logic              rx_accept_i,
  input  logic              rx_reject_i,
  input  logic              hit_bnd_i,
  input  logic [PAGE_W-1:0] end_page_i,
  output logic              recv_o,
  output logic              cfg_ok_o,
  output logic              load_o,
  output logic [PAGE_W-1:0] load_page_o,
  output logic [PAGE_W-1:0] curr_page_o,
  output logic              overflow_o
);
  rx_state_e         state_q;
  logic              init_q;
  logic [PAGE_W-1:0] curr_page_q;
  logic              go;

  assign cfg_ok_o    = page_stop_i > page_start_i;
  assign go          = init_q && cfg_ok_o && (state_q == ST_IDLE) && rx_start_i;
  assign load_o      = !init_q || go;
  assign load_page_o = init_q ? curr_page_q : page_start_i;
  assign recv_o      = (state_q == ST_RECV);
  assign curr_page_o = curr_page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      init_q      <= 1'b0;
      curr_page_q <= '0;
      overflow_o  <= 1'b0;
    end else if (!init_q) begin
      init_q      <= 1'b1;
      curr_page_q <= page_start_i;
    end else if (!cfg_ok_o) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (rx_start_i) begin
          state_q    <= ST_RECV;
          overflow_o <= 1'b0;
        end
        ST_RECV: begin
          if (hit_bnd_i) begin
            state_q    <= ST_DROP;
            overflow_o <= 1'b1;
          end else if (rx_accept_i) begin
            curr_page_q <= end_page_i;
            state_q     <= ST_IDLE;
          end else if (rx_reject_i) begin
            state_q <= ST_IDLE;
          end
        end
        ST_DROP: if (rx_accept_i || rx_reject_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_REJECT_KEEPS_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q && (state_q != ST_IDLE) && rx_reject_i) |=> $stable(curr_page_q)); // R6

  AST_DROP_KEEPS_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DROP) |=> $stable(curr_page_q)); // R7

  AST_CFG_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q && !cfg_ok_o) |=> (state_q == ST_IDLE)); // R9
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PAGE_W-1:0] page_start_i,
  input  logic [PAGE_W-1:0] page_stop_i,
  input  logic [PAGE_W-1:0] boundary_i,
  input  logic              rx_start_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_accept_i,
  input  logic              rx_reject_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              mem_we_o,
  output logic [PAGE_W-1:0] curr_page_o,
  output logic              overflow_o
);
  logic              recv;
  logic              cfg_ok;
  logic              load;
  logic [PAGE_W-1:0] load_page;
  logic              hit_bnd;
  logic [PAGE_W-1:0] end_page;

  rx_ring_ctrl #(.PAGE_W(PAGE_W)) ctrl_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .page_start_i(page_start_i),
    .page_stop_i (page_stop_i),
    .rx_start_i  (rx_start_i),
    .rx_accept_i (rx_accept_i),
    .rx_reject_i (rx_reject_i),
    .hit_bnd_i   (hit_bnd),
    .end_page_i  (end_page),
    .recv_o      (recv),
    .cfg_ok_o    (cfg_ok),
    .load_o      (load),
    .load_page_o (load_page),
    .curr_page_o (curr_page_o),
    .overflow_o  (overflow_o)
  );

  rx_ring_wptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) wptr_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_page_i (load_page),
    .recv_i      (recv),
    .cfg_ok_i    (cfg_ok),
    .rx_valid_i  (rx_valid_i),
    .rx_data_i   (rx_data_i),
    .boundary_i  (boundary_i),
    .page_start_i(page_start_i),
    .page_stop_i (page_stop_i),
    .hit_bnd_o   (hit_bnd),
    .end_page_o  (end_page),
    .mem_addr_o  (mem_addr_o),
    .mem_data_o  (mem_data_o),
    .mem_we_o    (mem_we_o)
  );

  AST_CFG_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_ok |=> !mem_we_o); // R9

  AST_OVF_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> !mem_we_o); // R7
endmodule

// File: tb/rx_ring_dma_tb_top.sv
module rx_ring_dma_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pg_start = 8'h40;
  logic [7:0]  pg_stop  = 8'h44;
  logic [7:0]  bnd      = 8'h43;
  logic        rx_start = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data  = 8'h00;
  logic        rx_accept = 1'b0;
  logic        rx_reject = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_data;
  logic        mem_we;
  logic [7:0]  curr_page;
  logic        overflow;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_dma dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .page_start_i(pg_start), .page_stop_i(pg_stop), .boundary_i(bnd),
    .rx_start_i(rx_start), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_accept_i(rx_accept), .rx_reject_i(rx_reject),
    .mem_addr_o(mem_addr), .mem_data_o(mem_data), .mem_we_o(mem_we),
    .curr_page_o(curr_page), .overflow_o(overflow)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] next_addr(input logic [15:0] a);
    logic [7:0] p;
    if (a[7:0] != 8'hFF) return a + 16'd1;
    p = a[15:8] + 8'd1;
    if (p == pg_stop) p = pg_start;
    return {p, 8'h00};
  endfunction

  task automatic strobe_start();
    @(negedge clk); rx_start = 1'b1;
    @(negedge clk); rx_start = 1'b0;
  endtask

  task automatic strobe_end(input logic keep);
    @(negedge clk); rx_accept = keep; rx_reject = !keep;
    @(negedge clk); rx_accept = 1'b0; rx_reject = 1'b0;
  endtask

  // sends n bytes from exp_addr on; returns count of misplaced writes
  task automatic send_bytes(input int n, input int seed, output int bad);
    bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = 8'(i * 7 + seed);
      @(negedge clk); rx_valid = 1'b0;
      if (!mem_we || mem_addr != exp_addr || mem_data != 8'(i * 7 + seed)) begin
        if (bad == 0)
          $display("byte %0d: we=%0b addr=%0h data=%0h, wanted addr=%0h", i, mem_we, mem_addr,
                   mem_data, exp_addr);
        bad++;
      end
      exp_addr = next_addr(exp_addr);
    end
  endtask

  task automatic send_blocked(input int n, output int wr);
    wr = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = 8'(i);
      @(negedge clk); rx_valid = 1'b0;
      if (mem_we) wr++;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", curr_page, 8'h40, "curr page after reset");
    check("R1", overflow, 0, "overflow after reset");
    check("R1", mem_we, 0, "write enable after reset");
  endtask

  task automatic t_short_accept();
    int bad;
    strobe_start();
    exp_addr = 16'h4000;
    send_bytes(10, 3, bad);
    check("R1", bad, 0, "first packet at start page offset 0");
    check("R2", bad, 0, "consecutive byte writes");
    strobe_end(1'b1);
    check("R5", curr_page, 8'h41, "curr page after short accept");
  endtask

  task automatic t_link();
    int bad;
    strobe_start();
    exp_addr = 16'h4100;
    send_bytes(300, 11, bad);
    check("R3", bad, 0, "packet linked into next page");
    check("R3", mem_addr, 16'h422B, "last address of linked packet");
    strobe_end(1'b1);
    check("R5", curr_page, 8'h43, "curr page after two-page packet");
  endtask

  task automatic t_wrap();
    int bad;
    @(negedge clk); bnd = 8'h41;
    strobe_start();
    exp_addr = 16'h4300;
    send_bytes(260, 5, bad);
    check("R4", bad, 0, "packet wraps from last page to start page");
    check("R4", mem_addr, 16'h4003, "last address after wrap");
    strobe_end(1'b1);
    check("R5", curr_page, 8'h41, "curr page after wrapped packet");
  endtask

  task automatic t_ovf_first();
    int wr;
    strobe_start();
    send_blocked(4, wr);
    check("R7", wr, 0, "no write into boundary page");
    check("R7", overflow, 1, "overflow set at boundary");
    strobe_end(1'b1);
    check("R7", curr_page, 8'h41, "accept after overflow keeps curr page");
    check("R7", overflow, 1, "overflow held until next start");
  endtask

  task automatic t_reclaim_reject();
    int bad;
    @(negedge clk); bnd = 8'h43;
    strobe_start();
    check("R7", overflow, 0, "start clears overflow");
    exp_addr = 16'h4100;
    send_bytes(5, 20, bad);
    check("R8", bad, 0, "freed page writable after boundary moved");
    strobe_end(1'b0);
    check("R6", curr_page, 8'h41, "reject keeps curr page");
    strobe_start();
    exp_addr = 16'h4100;
    send_bytes(3, 40, bad);
    check("R6", bad, 0, "next packet rewrites rejected page");
    strobe_end(1'b1);
    check("R5", curr_page, 8'h42, "curr page after accept");
  endtask

  task automatic t_ovf_mid();
    int bad;
    int wr;
    strobe_start();
    exp_addr = 16'h4200;
    send_bytes(256, 9, bad);
    check("R7", bad, 0, "bytes before boundary written");
    check("R7", overflow, 0, "no overflow before boundary entry");
    send_blocked(2, wr);
    check("R7", wr, 0, "no write after boundary reached mid-packet");
    check("R7", overflow, 1, "overflow set mid-packet");
    strobe_end(1'b1);
    check("R7", curr_page, 8'h42, "overflowed packet keeps curr page");
  endtask

  task automatic t_exact_page();
    int bad;
    strobe_start();
    exp_addr = 16'h4200;
    send_bytes(256, 1, bad);
    check("R5", bad, 0, "full-page packet written");
    strobe_end(1'b1);
    check("R5", overflow, 0, "exact page end not flagged");
    check("R5", curr_page, 8'h43, "curr page after exact page packet");
  endtask

  task automatic t_cfg_err();
    int wr;
    int bad;
    @(negedge clk); bnd = 8'h41; pg_stop = 8'h40;
    strobe_start();
    send_blocked(3, wr);
    strobe_end(1'b1);
    check("R9", wr, 0, "no write with stop equal to start");
    check("R9", curr_page, 8'h43, "curr page untouched under bad config");
    @(negedge clk); pg_stop = 8'h30;
    strobe_start();
    send_blocked(2, wr);
    strobe_end(1'b1);
    check("R9", wr, 0, "no write with stop below start");
    @(negedge clk); pg_stop = 8'h44;
    strobe_start();
    exp_addr = 16'h4300;
    send_bytes(4, 60, bad);
    check("R9", bad, 0, "writes resume after config fixed");
    strobe_end(1'b1);
    check("R9", curr_page, 8'h40, "curr page after recovery packet wraps");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_short_accept();
    t_link();
    t_wrap();
    t_ovf_first();
    t_reclaim_reject();
    t_ovf_mid();
    t_exact_page();
    t_cfg_err();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule